// File: doc/BRIEF.md
# Lane-Predicated SIMD Integer ALU

This block is a single-cycle vector integer datapath for a 128-bit register file. Each operation splits both operands into lanes whose width is chosen per operation: 8, 16 or 32 bits, giving 16, 8 or 4 lanes. Arithmetic is lane-local, so no carry crosses a lane boundary. The block offers a wrapping add, a signed saturating (fixed-point) add, and three signed lane compares.

A compare writes no vector result. It fills an internal 16-bit predicate register that holds one bit per byte of the vector, and a lane's outcome is copied into every byte that lane covers. A later arithmetic operation issued with its predicate input set writes its sum only into the bytes whose predicate bit is 1. All other bytes take the prior destination value supplied by the caller. Because the predicate is kept per byte, a mask made at one lane width can gate an operation at another.

Results are registered, with one cycle of latency, and the predicate register is visible on an output port.

Top module: `lane_simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), and 2 or 3 give 32 bits (4 lanes).
- R2: Opcode 0 (wrapping add) adds each lane modulo 2^width. A carry propagates inside a lane and never into the next lane.
- R3: Opcode 1 (saturating add) returns the lane sum when it fits the signed range. On positive overflow it returns the most positive value (7F, 7FFF or 7FFFFFFF). On negative overflow it returns the most negative value (80, 8000 or 80000000).
- R4: Opcodes 2, 3 and 4 compare lanes of `src_a` against `src_b` as equal, signed greater-than and signed greater-or-equal. The outcome of lane k is written into predicate bits for every byte of lane k: bit j covers bits 8j+7..8j of the vector.
- R5: A compare drives `res_data` with `dst_prev` and performs no arithmetic.
- R6: For an add with `pred_en` = 1, every byte whose predicate bit is 1 receives the computed byte. Every other byte receives the matching byte of `dst_prev`.
- R7: An add with `pred_en` = 0 writes all lanes regardless of the predicate. Add operations never change the predicate register.
- R8: `res_valid` equals `op_valid` from the previous cycle. While `op_valid` is 0, `res_data` and `pred_mask` hold their values.
- R9: While `rst_n` is low, `res_valid`, `res_data` and `pred_mask` are all zero.
- R10: A predicated add issued in the cycle right after a compare uses the predicate that compare produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 add, 1 saturating add, 2 eq, 3 gt, 4 ge |
| lane_sz | input | 2 | Lane width select |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| dst_prev | input | 128 | Prior destination value |
| pred_en | input | 1 | Mask the add with the predicate |
| res_valid | output | 1 | Result valid |
| res_data | output | 128 | Registered result |
| pred_mask | output | 16 | Predicate register, one bit per byte |

## Verification
The predicate write from a compare and the predicate read by a masked add can fall on the same clock edge. The bench provokes this by issuing a compare and then a predicated add in the very next cycle, with no idle cycle between them. The add's result must follow the new mask byte by byte, not the stale one. The bench also gates with a mask made at a different lane width than the add that uses it, and judges the merged result against a value computed by hand.

// File: rtl/lane_simd_alu.sv
module lane_simd_alu #(
  parameter int VW = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [1:0]      lane_sz,
  input  logic [VW-1:0]   src_a,
  input  logic [VW-1:0]   src_b,
  input  logic [VW-1:0]   dst_prev,
  input  logic            pred_en,
  output logic            res_valid,
  output logic [VW-1:0]   res_data,
  output logic [VW/8-1:0] pred_mask
);
  localparam int NB = VW / 8;
  localparam int NH = VW / 16;
  localparam int NW = VW / 32;

  logic is_arith, is_cmp;
  assign is_arith = (op_code == 3'd0) || (op_code == 3'd1);
  assign is_cmp   = (op_code >= 3'd2) && (op_code <= 3'd4);

  logic [VW-1:0] add8, add16, add32, sat8, sat16, sat32;
  logic [NB-1:0] ov8, c8, c16, c32;
  logic [NH-1:0] ov16;
  logic [NW-1:0] ov32;

  function automatic logic pick(input logic [2:0] oc, input logic eq, input logic gt);
    return (oc == 3'd2) ? eq : (oc == 3'd3) ? gt : (gt || eq);
  endfunction

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      add8[i*8+:8] = src_a[i*8+:8] + src_b[i*8+:8];
      ov8[i] = (src_a[i*8+7] == src_b[i*8+7]) && (add8[i*8+7] != src_a[i*8+7]);
      sat8[i*8+:8] = ov8[i] ? (src_a[i*8+7] ? 8'h80 : 8'h7F) : add8[i*8+:8];
      c8[i] = pick(op_code, src_a[i*8+:8] == src_b[i*8+:8],
                   $signed(src_a[i*8+:8]) > $signed(src_b[i*8+:8]));
    end
    for (int i = 0; i < NH; i++) begin
      add16[i*16+:16] = src_a[i*16+:16] + src_b[i*16+:16];
      ov16[i] = (src_a[i*16+15] == src_b[i*16+15]) && (add16[i*16+15] != src_a[i*16+15]);
      sat16[i*16+:16] = ov16[i] ? (src_a[i*16+15] ? 16'h8000 : 16'h7FFF) : add16[i*16+:16];
      c16[i*2+:2] = {2{pick(op_code, src_a[i*16+:16] == src_b[i*16+:16],
                            $signed(src_a[i*16+:16]) > $signed(src_b[i*16+:16]))}};
    end
    for (int i = 0; i < NW; i++) begin
      add32[i*32+:32] = src_a[i*32+:32] + src_b[i*32+:32];
      ov32[i] = (src_a[i*32+31] == src_b[i*32+31]) && (add32[i*32+31] != src_a[i*32+31]);
      sat32[i*32+:32] = ov32[i] ? (src_a[i*32+31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : add32[i*32+:32];
      c32[i*4+:4] = {4{pick(op_code, src_a[i*32+:32] == src_b[i*32+:32],
                            $signed(src_a[i*32+:32]) > $signed(src_b[i*32+:32]))}};
    end
  end

  logic [VW-1:0] calc, wmask, merged;
  logic [NB-1:0] cond;

  always_comb begin
    case (lane_sz)
      2'd0:    begin calc = op_code[0] ? sat8  : add8;  cond = c8;  end
      2'd1:    begin calc = op_code[0] ? sat16 : add16; cond = c16; end
      default: begin calc = op_code[0] ? sat32 : add32; cond = c32; end
    endcase
    for (int i = 0; i < NB; i++) wmask[i*8+:8] = {8{pred_mask[i]}};
  end

  assign merged = pred_en ? ((calc & wmask) | (dst_prev & ~wmask)) : calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      pred_mask <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data <= is_arith ? merged : dst_prev;
        if (is_cmp) pred_mask <= cond;
      end
    end
  end
endmodule

module lane_simd_alu_chk #(
  parameter int VW = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [1:0]      lane_sz,
  input logic [VW-1:0]   dst_prev,
  input logic            pred_en,
  input logic            res_valid,
  input logic [VW-1:0]   res_data,
  input logic [VW/8-1:0] pred_mask
);
  localparam int NB = VW / 8;
  logic arith, cmpop;
  logic [VW-1:0] upd;
  logic [NB-1:0] even_bits, odd_bits, quad_base;

  assign arith = (op_code == 3'd0) || (op_code == 3'd1);
  assign cmpop = (op_code >= 3'd2) && (op_code <= 3'd4);

  always_comb begin
    for (int i = 0; i < NB; i++) upd[i*8+:8] = {8{pred_mask[i]}};
    for (int i = 0; i < NB; i++) begin
      even_bits[i] = (i % 2 == 0) ? pred_mask[i] : pred_mask[i-1];
      odd_bits[i]  = pred_mask[i];
      quad_base[i] = pred_mask[i - (i % 4)];
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_data) && $stable(pred_mask)));

  assert_add_keeps_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cmpop) |=> $stable(pred_mask));

  assert_cmp_passes_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmpop) |=> (res_data == $past(dst_prev)));

  assert_masked_bytes_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && arith && pred_en) |=> (((res_data ^ $past(dst_prev)) & ~$past(upd)) == '0));

  assert_half_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmpop && lane_sz == 2'd1) |=> (even_bits == odd_bits));

  assert_word_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmpop && lane_sz[1]) |=> (quad_base == pred_mask));
endmodule

bind lane_simd_alu lane_simd_alu_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .lane_sz(lane_sz), .dst_prev(dst_prev), .pred_en(pred_en),
  .res_valid(res_valid), .res_data(res_data), .pred_mask(pred_mask)
);

// File: tb/sim_lane_simd_alu.sv
module sim_lane_simd_alu;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, pred_en = 1'b0;
  logic [2:0] op_code = '0;
  logic [1:0] lane_sz = '0;
  logic [127:0] src_a = '0, src_b = '0, dst_prev = '0;
  logic res_valid;
  logic [127:0] res_data;
  logic [15:0] pred_mask;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  lane_simd_alu u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lane_sz(lane_sz), .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
    .pred_en(pred_en), .res_valid(res_valid), .res_data(res_data), .pred_mask(pred_mask));

  localparam int NV = 9;
  localparam logic [388:0] VEC [NV] = '{
    {3'd0, 2'd0, {16{8'h7F}}, {16{8'h01}}, {16{8'h80}}},
    {3'd0, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, 128'h0},
    {3'd0, 2'd2, {4{32'h0000_FFFF}}, {4{32'h0000_0001}}, {4{32'h0001_0000}}},
    {3'd0, 2'd3, {4{32'h0000_FFFF}}, {4{32'h0000_0001}}, {4{32'h0001_0000}}},
    {3'd1, 2'd0, {16{8'h7F}}, {16{8'h01}}, {16{8'h7F}}},
    {3'd1, 2'd0, {16{8'h80}}, {16{8'hFF}}, {16{8'h80}}},
    {3'd1, 2'd1, {8{16'h7000}}, {8{16'h2000}}, {8{16'h7FFF}}},
    {3'd1, 2'd2, {4{32'h8000_0001}}, {4{32'hFFFF_FFF0}}, {4{32'h8000_0000}}},
    {3'd1, 2'd1, {8{16'h0005}}, {8{16'hFFFD}}, {8{16'h0002}}}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] oc, input logic [1:0] sz, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] d, input logic pe);
    @(negedge clk);
    op_valid = 1'b1; op_code = oc; lane_sz = sz;
    src_a = a; src_b = b; dst_prev = d; pred_en = pe;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0; src_a = '1; dst_prev = '1; op_code = 3'd2;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #9;
    chk("R9 reset valid", {127'd0, res_valid}, 128'd0);
    chk("R9 reset data", res_data, 128'd0);
    chk("R9 reset pred", {112'd0, pred_mask}, 128'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][388:386], VEC[i][385:384], VEC[i][383:256], VEC[i][255:128],
            {4{32'hDEAD_BEEF}}, 1'b0);
      chk($sformatf("R1 R2 R3 R7 vector %0d", i), res_data, VEC[i][127:0]);
      chk("R8 valid", {127'd0, res_valid}, 128'd1);
    end

    idle();
    chk("R8 idle valid", {127'd0, res_valid}, 128'd0);
    chk("R8 idle hold", res_data, {8{16'h0002}});

    issue(3'd2, 2'd0, {8{8'h11, 8'h22}}, {16{8'h11}}, {4{32'hCAFE_F00D}}, 1'b0);
    chk("R4 eq8 pred", {112'd0, pred_mask}, {112'd0, 16'hAAAA});
    chk("R5 cmp result", res_data, {4{32'hCAFE_F00D}});
    issue(3'd0, 2'd0, {16{8'h10}}, {16{8'h01}}, {16{8'h55}}, 1'b1);
    chk("R10 R6 back-to-back masked add", res_data, {8{8'h11, 8'h55}});

    issue(3'd3, 2'd1, {4{16'h0002, 16'h8000}}, {8{16'h0001}}, 128'h0, 1'b0);
    chk("R4 gt16 pred", {112'd0, pred_mask}, {112'd0, 16'hCCCC});

    issue(3'd4, 2'd2, {32'h5, 32'h4, 32'h3, 32'h4}, {4{32'h4}}, 128'h0, 1'b0);
    chk("R4 ge32 pred", {112'd0, pred_mask}, {112'd0, 16'hFF0F});
    issue(3'd0, 2'd2, {4{32'h1}}, {4{32'h1}}, {4{32'hAAAA_AAAA}}, 1'b1);
    chk("R10 R6 masked add32", res_data, {32'h2, 32'h2, 32'hAAAA_AAAA, 32'h2});
    issue(3'd0, 2'd2, {4{32'h1}}, {4{32'h1}}, {4{32'hAAAA_AAAA}}, 1'b0);
    chk("R7 unmasked add", res_data, {4{32'h2}});
    chk("R7 pred kept", {112'd0, pred_mask}, {112'd0, 16'hFF0F});

    issue(3'd1, 2'd1, {8{16'h7FFF}}, {8{16'h0001}}, {8{16'h1234}}, 1'b1);
    chk("R3 R6 masked sat16", res_data,
        {{4{16'h7FFF}}, 16'h1234, 16'h1234, 16'h7FFF, 16'h7FFF});

    idle();
    chk("R8 idle pred", {112'd0, pred_mask}, {112'd0, 16'hFF0F});
    chk("R8 idle valid2", {127'd0, res_valid}, 128'd0);

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9 mid reset pred", {112'd0, pred_mask}, 128'd0);
    chk("R9 mid reset data", res_data, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule